// File: doc/BRIEF.md
# SMI Request Sequencing Controller

This block sequences entry into and exit from system management mode for a small processor core. A falling edge on the active-low SMI request line, brought through a synchronizer, starts an SMM session: the block drives its active-low SMM-active output low and raises an entry request to the core. The entry request stays high until the core reports that its state save has finished.

Requests that arrive while a session is running never start a nested session. They are folded into a single pending flag. When the core reports that the resume instruction has completed, the block releases SMM-active for one clock. If a request is pending, it then starts a fresh session for it. A halt executed by the handler sets a halted flag, and INTR or NMI clears it. That flag has no influence on the SMM sequencing.

Top module: `smi_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset drives smiact_n high, smm_enter low and halted low, and discards any pending request.
- R2: A high-to-low change of smi_req_n seen by the SYNC_DEPTH-stage synchronizer (default 2) starts a session while the block is idle. With the default depth, smiact_n goes low and smm_enter goes high at the third rising clock edge after the input falls. A line that stays low counts as a single request.
- R3: A request that arrives while a session is active does not start a nested entry. smiact_n stays low and smm_enter does not rise again.
- R4: A request held pending at resume is replayed. smiact_n is high for exactly one clock after the edge that samples rsm_done, then goes low again with smm_enter high. The pending flag is cleared on the edge where the replay starts.
- R5: Any number of requests during one session merge into one pending request, which produces exactly one replayed session.
- R6: A request edge that reaches the state logic in the same cycle that rsm_done is sampled is kept as pending and replayed.
- R7: smm_enter rises when a session starts and stays high until save_done is sampled. rsm_done is ignored while smm_enter is high.
- R8: A resume with nothing pending returns the block to idle, and smiact_n stays high.
- R9: halt_exec sets halted on the next edge, and intr or nmi clears it (halt_exec wins when both arrive in the same cycle). halted never changes smiact_n or smm_enter.
- R10: save_done and rsm_done have no effect while no session is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smi_req_n | input | 1 | Asynchronous SMI request, active low, edge-counted |
| save_done | input | 1 | One-cycle pulse: the core finished its state save |
| rsm_done | input | 1 | One-cycle pulse: the resume instruction completed |
| halt_exec | input | 1 | One-cycle pulse: the core executed a halt |
| intr | input | 1 | Maskable interrupt, wakes from halt |
| nmi | input | 1 | Non-maskable interrupt, wakes from halt |
| smiact_n | output | 1 | SMM active, active low |
| smm_enter | output | 1 | SMM entry request to the core |
| halted | output | 1 | Core is halted |

## Verification
A request edge on smi_req_n shows up at the outputs three rising edges after the pin falls: two synchronizer stages, then the state register. rsm_done, save_done, halt_exec, intr and nmi each act on the first edge that samples them, and a replay follows the resume gap one edge later. The bench keeps a behavioural model that holds the pin history in a queue and applies these delays. It compares all three outputs at every falling edge, between updates. Directed checks measure the gap width, count replayed sessions, and place a request edge on the same cycle as the resume pulse.

// File: rtl/smi_seq_ctrl.sv
module smi_seq_ctrl #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic smi_req_n,
  input  logic save_done,
  input  logic rsm_done,
  input  logic halt_exec,
  input  logic intr,
  input  logic nmi,
  output logic smiact_n,
  output logic smm_enter,
  output logic halted
);
  typedef enum logic [1:0] {ST_NORMAL, ST_SMM, ST_GAP} state_t;

  state_t            state_q;
  logic              pend_q;
  logic              enter_q;
  logic              halt_q;
  logic [SYNC_DEPTH:0] sync_q;
  logic              req_edge;
  logic              take;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_DEPTH-1:0], smi_req_n};
  end

  assign req_edge = sync_q[SYNC_DEPTH] & ~sync_q[SYNC_DEPTH-1];
  assign take = (state_q == ST_NORMAL && req_edge) ||
                (state_q == ST_GAP && (req_edge || pend_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_NORMAL;
      pend_q  <= 1'b0;
      enter_q <= 1'b0;
    end else if (take) begin
      state_q <= ST_SMM;
      pend_q  <= 1'b0;
      enter_q <= 1'b1;
    end else begin
      case (state_q)
        ST_SMM: begin
          if (req_edge)             pend_q  <= 1'b1;
          if (save_done)            enter_q <= 1'b0;
          if (rsm_done && !enter_q) state_q <= ST_GAP;
        end
        ST_GAP:  state_q <= ST_NORMAL;
        default: state_q <= ST_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               halt_q <= 1'b0;
    else if (halt_exec)    halt_q <= 1'b1;
    else if (intr || nmi)  halt_q <= 1'b0;
  end

  assign smiact_n  = (state_q != ST_SMM);
  assign smm_enter = enter_q;
  assign halted    = halt_q;
endmodule

module smi_seq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic save_done,
  input logic halt_exec,
  input logic intr,
  input logic nmi,
  input logic smiact_n,
  input logic smm_enter,
  input logic halted,
  input logic pend_q
);
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (smiact_n && !smm_enter && !halted && !pend_q));
  p_no_nest_r3: assert property (@(posedge clk) disable iff (rst)
    (!smiact_n && $past(!smiact_n)) |-> !$rose(smm_enter));
  p_gap_replay_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(smiact_n) && pend_q) |=> (!smiact_n && smm_enter && !pend_q));
  p_enter_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (smm_enter && !save_done) |=> smm_enter);
  p_enter_in_smm_r7: assert property (@(posedge clk) disable iff (rst)
    smm_enter |-> !smiact_n);
  p_halt_set_r9: assert property (@(posedge clk) disable iff (rst)
    halt_exec |=> halted);
  p_wake_r9: assert property (@(posedge clk) disable iff (rst)
    (!halt_exec && (intr || nmi)) |=> !halted);
endmodule

bind smi_seq_ctrl smi_seq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .save_done(save_done), .halt_exec(halt_exec),
  .intr(intr), .nmi(nmi), .smiact_n(smiact_n), .smm_enter(smm_enter),
  .halted(halted), .pend_q(pend_q)
);

// File: tb/smi_seq_ctrl_bench.sv
module smi_seq_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smi_req_n = 1'b1;
  logic save_done = 1'b0, rsm_done = 1'b0, halt_exec = 1'b0, intr = 1'b0, nmi = 1'b0;
  logic smiact_n, smm_enter, halted;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  smi_seq_ctrl u_smi_seq_ctrl (
    .clk(clk), .rst(rst), .smi_req_n(smi_req_n), .save_done(save_done),
    .rsm_done(rsm_done), .halt_exec(halt_exec), .intr(intr), .nmi(nmi),
    .smiact_n(smiact_n), .smm_enter(smm_enter), .halted(halted)
  );

  // Behavioural reference: 0 idle, 1 in session, 2 resume gap
  bit pin_hist[$];
  int m_mode = 0;
  bit m_pend = 0, m_enter = 0, m_halt = 0;
  int sessions = 0;

  always @(posedge clk) begin
    bit e;
    pin_hist.push_front(smi_req_n);
    if (pin_hist.size() > 4) void'(pin_hist.pop_back());
    if (rst) begin
      pin_hist = {1'b1, 1'b1, 1'b1, 1'b1};
      m_mode = 0; m_pend = 0; m_enter = 0; m_halt = 0;
    end else begin
      e = (pin_hist.size() == 4) && pin_hist[3] && !pin_hist[2];
      if (m_mode == 0) begin
        if (e) begin m_mode = 1; m_enter = 1; sessions++; end
      end else if (m_mode == 1) begin
        bit rs;
        rs = rsm_done && !m_enter;
        if (e) m_pend = 1;
        if (save_done) m_enter = 0;
        if (rs) m_mode = 2;
      end else begin
        if (m_pend || e) begin m_mode = 1; m_pend = 0; m_enter = 1; sessions++; end
        else m_mode = 0;
      end
      if (halt_exec) m_halt = 1;
      else if (intr || nmi) m_halt = 0;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      check(cur_req, "smiact_n", smiact_n, m_mode != 1);
      check(cur_req, "smm_enter", smm_enter, m_enter);
      check(cur_req, "halted", halted, m_halt);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; step(1); s = 1'b0;
  endtask

  task automatic smi_edge();
    smi_req_n = 1'b0; step(2); smi_req_n = 1'b1; step(2);
  endtask

  initial begin
    int gap;
    int s0;
    @(negedge clk);
    cur_req = "R1"; step(3);
    rst = 1'b0; step(2);
    check("R1", "smiact_n after reset", smiact_n, 1'b1);
    check("R1", "smm_enter after reset", smm_enter, 1'b0);

    // R10: pulses while idle do nothing
    cur_req = "R10"; pulse(save_done); pulse(rsm_done); step(2);
    check("R10", "still idle", smiact_n, 1'b1);

    // R2: entry latency and level hold
    cur_req = "R2";
    smi_req_n = 1'b0; step(2);
    check("R2", "not yet active at edge 2", smiact_n, 1'b1);
    step(1);
    check("R2", "active at edge 3", smiact_n, 1'b0);
    check("R2", "enter raised", smm_enter, 1'b1);
    step(6);

    // R7: resume ignored while enter high, then save clears it
    cur_req = "R7"; pulse(rsm_done); step(1);
    check("R7", "rsm ignored during save", smiact_n, 1'b0);
    pulse(save_done);
    check("R7", "enter cleared by save", smm_enter, 1'b0);

    // R8: resume with nothing pending (line held low all along)
    cur_req = "R8"; pulse(rsm_done);
    check("R8", "gap after resume", smiact_n, 1'b1);
    step(4);
    check("R8", "stays idle", smiact_n, 1'b1);
    smi_req_n = 1'b1; step(3);

    // R3, R5: nested requests merge
    cur_req = "R3"; smi_edge(); step(1);
    pulse(save_done);
    s0 = sessions;
    smi_edge(); smi_edge(); smi_edge(); step(1);
    check("R3", "no nested entry", smm_enter, 1'b0);
    check("R3", "still active", smiact_n, 1'b0);

    // R4: one-cycle gap then replay
    cur_req = "R4"; rsm_done = 1'b1; step(1); rsm_done = 1'b0;
    gap = 0;
    while (smiact_n && gap < 10) begin gap++; step(1); end
    check("R4", "gap of one clock", gap == 1, 1'b1);
    check("R4", "replay enter", smm_enter, 1'b1);
    pulse(save_done);
    cur_req = "R5"; pulse(rsm_done); step(5);
    check("R5", "single replay", (sessions - s0) == 1, 1'b1);
    check("R5", "idle after replay", smiact_n, 1'b1);

    // R6: request edge coincides with resume sample
    cur_req = "R6"; smi_edge(); step(1); pulse(save_done);
    smi_req_n = 1'b0; step(2);
    rsm_done = 1'b1; step(1); rsm_done = 1'b0;
    check("R6", "gap", smiact_n, 1'b1);
    step(1);
    check("R6", "replayed", smiact_n, 1'b0);
    smi_req_n = 1'b1; pulse(save_done);

    // R9: halt and wake inside a session
    cur_req = "R9"; pulse(halt_exec);
    check("R9", "halted set", halted, 1'b1);
    check("R9", "smm unchanged", smiact_n, 1'b0);
    pulse(intr);
    check("R9", "intr wakes", halted, 1'b0);
    pulse(halt_exec); halt_exec = 1'b1; nmi = 1'b1; step(1);
    halt_exec = 1'b0; check("R9", "halt wins", halted, 1'b1);
    step(1); nmi = 1'b0;
    check("R9", "nmi wakes", halted, 1'b0);
    pulse(rsm_done); step(2);
    pulse(halt_exec);
    check("R9", "halt in normal", halted, 1'b1);

    // R1: reset mid-session discards pending
    cur_req = "R1"; smi_edge(); step(1); smi_edge();
    rst = 1'b1; step(2); rst = 1'b0; step(6);
    check("R1", "pending discarded", smiact_n, 1'b1);
    check("R1", "halted cleared", halted, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule